// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. Either clock may be the faster one, and reads and writes may happen in the same cycle. Words are stored in a dual-port memory of 2^AW entries. Each side keeps its own binary pointer. A Gray-coded copy of each pointer crosses to the other clock through a two-flop synchronizer. The write side produces the full/input-ready, half-full and almost-full flags. The read side produces the empty/output-ready and almost-empty flags.

The timing mode is latched at master reset. In standard mode a word reaches `rd_data` one read clock after a read request, and `rd_flag` means "empty". In fall-through mode the oldest word is presented on `rd_data` without a request, and `rd_flag` means "a word is valid". A consumed word is replaced on the next read clock. The two almost-flag thresholds live in one offset register. It can be loaded serially, one bit per write clock, or as two words taken from the data bus. Master reset sets both thresholds to one of two preset values. Partial reset empties the buffer but keeps the thresholds and the mode. Retransmit rewinds reading to the first word written since the last reset.

Top module: `dcfifo_pflag`

## Requirements
- R1: Words leave the buffer in the order they were accepted, and each word is unchanged, for any mix of reads and writes on the two independent clocks.
- R2: In standard mode (`fwft_sel` low at master reset), `rd_flag` is 1 while no word is stored. `rd_data` changes only on the read clock after an accepted read, and then shows the oldest word.
- R3: In fall-through mode (`fwft_sel` high at master reset), `rd_flag` is 1 while a valid word is on `rd_data`. The oldest word appears there without a read, and it stays until a read consumes it.
- R4: `wr_flag` is 1 when the memory is full in standard mode. In fall-through mode it is 1 when there is room. A data write while full is dropped. Capacity is 2^AW words in standard mode and 2^AW+1 in fall-through mode.
- R5: A read request while the buffer is empty is ignored. It changes neither `rd_data` nor the read position.
- R6: `half_full` is 1 when the memory array holds more than 2^(AW-1) words.
- R7: `almost_empty` is 1 when the stored word count is at or below the empty threshold. In fall-through mode the count includes the word on the output.
- R8: `almost_full` is 1 when the free memory entries are at or below the full threshold.
- R9: Master reset empties the buffer and latches the mode from `fwft_sel`. It sets both thresholds to `DEF_LO` (7) when `def_sel` is 0, or to `DEF_HI` (15) when `def_sel` is 1.
- R10: Partial reset empties the buffer but keeps both thresholds and the latched mode.
- R11: A write with `ld` high stores no data. It takes `wr_data[AW-1:0]` as a threshold: the first such write after a reset sets the empty threshold, the next sets the full threshold, and so on alternately.
- R12: Each write clock with `ser_en` high shifts `ser_din` into the threshold register. After 2·AW shifts, the first bit shifted in is bit 0 of the empty threshold, and the last bit shifted in is the top bit of the full threshold.
- R13: A one-cycle `rt` pulse makes reading restart from the first word written since the last reset. In fall-through mode that word falls through to `rd_data` again.
- R14: A word written into an empty buffer is readable within four read clocks. The delay does not depend on the clock ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, held for at least three cycles of each clock |
| prst | input | 1 | Partial reset, active high, held for at least three cycles of each clock |
| fwft_sel | input | 1 | Timing mode sampled at master reset: 0 standard, 1 fall-through |
| def_sel | input | 1 | Default threshold select sampled at master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data, or threshold word when `ld` is high |
| ld | input | 1 | Turns a write into a parallel threshold load |
| ser_en | input | 1 | Serial threshold shift enable |
| ser_din | input | 1 | Serial threshold data bit |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Retransmit pulse |
| rd_data | output | DW | Output data register |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| half_full | output | 1 | More than half the memory occupied |
| almost_empty | output | 1 | Count at or below the empty threshold |
| almost_full | output | 1 | Free space at or below the full threshold |

## Verification
On every cycle, the assertions check the following. A write while full or a load write leaves the write pointer unchanged. In standard mode the output register moves only on a read, and a read while empty moves nothing. A valid fall-through word holds until it is consumed. Retransmit rewinds the read pointer. Partial reset leaves the thresholds and the mode untouched. Only the bench scenarios can show end-to-end data order across the clock crossing, the exact flag values at each fill level, the threshold loading sequences, the reset defaults and the word replayed after retransmit.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} tmode_e;
  typedef enum logic {TGT_EMPTY_OFF = 1'b0, TGT_FULL_OFF = 1'b1} ldtgt_e;
endpackage

// File: rtl/dcf_sync.sv
// Two-flop synchronizer for a Gray-coded pointer.
module dcf_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
// Simple dual-port memory with a registered read port (block RAM shape).
module dcf_ram #(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
// Write-domain pointer, full / half-full / almost-full flags, threshold register.
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int AW     = 6,
  parameter int DEF_LO = 7,
  parameter int DEF_HI = 15
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic          def_sel,
  input  logic          wr_en,
  input  logic          ld,
  input  logic [AW-1:0] ld_word,
  input  logic          ser_en,
  input  logic          ser_din,
  input  logic [AW:0]   rq_gray,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          wr_flag,
  output logic          half_full,
  output logic          almost_full,
  output logic [AW-1:0] off_e
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << AW);
  localparam logic [PW-1:0] HALF_V  = PW'(1 << (AW - 1));

  logic            rst;
  tmode_e          mode_q;
  ldtgt_e          tgt_q;
  logic [PW-1:0]   wr_bin, wr_next, rq_bin, lvl_next, wgray_next;
  logic [2*AW-1:0] offs;
  logic            full_q, hf_q, af_q;

  assign rst = mrst | prst;

  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign rq_bin[i] = ^rq_gray[PW-1:i];
  end

  assign we         = wr_en && !ld && !ser_en && !full_q;
  assign wr_next    = wr_bin + PW'(we);
  assign wgray_next = wr_next ^ (wr_next >> 1);
  assign lvl_next   = wr_next - rq_bin;
  assign waddr      = wr_bin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bin <= '0;
      wgray  <= '0;
      full_q <= 1'b0;
      hf_q   <= 1'b0;
      af_q   <= 1'b0;
    end else begin
      wr_bin <= wr_next;
      wgray  <= wgray_next;
      full_q <= (wgray_next == {~rq_gray[PW-1:PW-2], rq_gray[PW-3:0]});
      hf_q   <= lvl_next > HALF_V;
      af_q   <= (DEPTH_V - lvl_next) <= {1'b0, offs[2*AW-1:AW]};
    end
  end

  // Threshold register and latched mode.
  always_ff @(posedge clk) begin
    if (mrst) begin
      mode_q <= tmode_e'(fwft_sel);
      tgt_q  <= TGT_EMPTY_OFF;
      offs   <= def_sel ? {2{AW'(DEF_HI)}} : {2{AW'(DEF_LO)}};
    end else if (prst) begin
      tgt_q <= TGT_EMPTY_OFF;
    end else if (ser_en) begin
      offs <= {ser_din, offs[2*AW-1:1]};
    end else if (wr_en && ld) begin
      if (tgt_q == TGT_EMPTY_OFF) offs[AW-1:0]    <= ld_word;
      else                        offs[2*AW-1:AW] <= ld_word;
      tgt_q <= (tgt_q == TGT_EMPTY_OFF) ? TGT_FULL_OFF : TGT_EMPTY_OFF;
    end
  end

  assign wr_flag     = (mode_q == MODE_FWFT) ? !full_q : full_q;
  assign half_full   = hf_q;
  assign almost_full = af_q;
  assign off_e       = offs[AW-1:0];

  // R4: a data write while full leaves the write pointer unchanged.
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (full_q && wr_en && !ld && !ser_en) |=> $stable(wr_bin));

  // R11: a threshold load write never advances the write pointer.
  assert_load_no_store_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ld) |=> $stable(wr_bin));

  // R10: partial reset keeps thresholds and mode.
  assert_prst_keeps_cfg_R10: assert property (@(posedge clk) disable iff (mrst)
    prst |=> ($stable(offs) && $stable(mode_q)));
endmodule

// File: rtl/dcf_rd_ctl.sv
// Read-domain pointer, output staging, empty / output-ready / almost-empty.
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic          rt,
  input  logic          rd_en,
  input  logic [AW:0]   wq_gray,
  input  logic [AW-1:0] off_e,
  input  logic [DW-1:0] rd_data,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          rd_flag,
  output logic          almost_empty
);
  localparam int PW = AW + 1;

  logic          rst;
  tmode_e        mode_q;
  logic [PW-1:0] rd_bin, rd_next, wq_bin, lvl_next, rgray_next;
  logic          mem_empty_q, ov_q, ov_next, ae_q, fetch, is_fwft;

  assign rst     = mrst | prst;
  assign is_fwft = (mode_q == MODE_FWFT);

  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign wq_bin[i] = ^wq_gray[PW-1:i];
  end

  assign fetch      = !mem_empty_q && !rt && (is_fwft ? (!ov_q || rd_en) : rd_en);
  assign rd_next    = rt ? '0 : rd_bin + PW'(fetch);
  assign ov_next    = is_fwft && !rt && (fetch || (ov_q && !rd_en));
  assign rgray_next = rd_next ^ (rd_next >> 1);
  assign lvl_next   = wq_bin - rd_next + PW'(ov_next);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bin      <= '0;
      rgray       <= '0;
      mem_empty_q <= 1'b1;
      ov_q        <= 1'b0;
      ae_q        <= 1'b1;
    end else begin
      rd_bin      <= rd_next;
      rgray       <= rgray_next;
      mem_empty_q <= (rgray_next == wq_gray);
      ov_q        <= ov_next;
      ae_q        <= lvl_next <= {1'b0, off_e};
    end
  end

  always_ff @(posedge clk) begin
    if (mrst) mode_q <= tmode_e'(fwft_sel);
  end

  assign re           = fetch;
  assign raddr        = rd_bin[AW-1:0];
  assign rd_flag      = is_fwft ? ov_q : mem_empty_q;
  assign almost_empty = ae_q;

  // R5: a read while empty moves neither pointer nor output.
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    (!is_fwft && mem_empty_q && rd_en && !rt) |=> ($stable(rd_bin) && $stable(rd_data)));

  // R2: in standard mode the output register changes only after a read.
  assert_std_out_on_read_R2: assert property (@(posedge clk) disable iff (rst)
    (!is_fwft && !rd_en) |=> $stable(rd_data));

  // R3: a presented fall-through word holds until consumed.
  assert_fwft_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (is_fwft && ov_q && !rd_en && !rt) |=> (ov_q && $stable(rd_data)));

  // R13: retransmit rewinds reading to the first location.
  assert_rt_rewind_R13: assert property (@(posedge clk) disable iff (rst)
    rt |=> (rd_bin == '0));
endmodule

// File: rtl/dcfifo_pflag.sv
// Dual-clock FIFO with programmable almost-empty / almost-full thresholds.
module dcfifo_pflag #(
  parameter int DW     = 18,
  parameter int AW     = 6,
  parameter int DEF_LO = 7,
  parameter int DEF_HI = 15
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic          def_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          ld,
  input  logic          ser_en,
  input  logic          ser_din,
  input  logic          rd_en,
  input  logic          rt,
  output logic [DW-1:0] rd_data,
  output logic          rd_flag,
  output logic          wr_flag,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int PW = AW + 1;

  logic          any_rst;
  logic          we, re;
  logic [AW-1:0] waddr, raddr, off_e;
  logic [PW-1:0] wgray, rgray, wq_gray, rq_gray;

  assign any_rst = mrst | prst;

  dcf_wr_ctl #(.AW(AW), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_wr (
    .clk(wr_clk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel), .def_sel(def_sel),
    .wr_en(wr_en), .ld(ld), .ld_word(wr_data[AW-1:0]), .ser_en(ser_en), .ser_din(ser_din),
    .rq_gray(rq_gray), .we(we), .waddr(waddr), .wgray(wgray), .wr_flag(wr_flag),
    .half_full(half_full), .almost_full(almost_full), .off_e(off_e)
  );

  dcf_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst(any_rst), .d(wgray), .q(wq_gray));
  dcf_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst(any_rst), .d(rgray), .q(rq_gray));

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rrst(any_rst), .re(re), .raddr(raddr), .rdata(rd_data)
  );

  dcf_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
    .clk(rd_clk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel), .rt(rt), .rd_en(rd_en),
    .wq_gray(wq_gray), .off_e(off_e), .rd_data(rd_data), .re(re), .raddr(raddr),
    .rgray(rgray), .rd_flag(rd_flag), .almost_empty(almost_empty)
  );
endmodule

// File: tb/dcfifo_pflag_tb_top.sv
module dcfifo_pflag_tb_top;
  localparam int DW = 18;
  localparam int DEPTH = 64;

  logic wr_clk = 0, rd_clk = 0;
  logic mrst = 1, prst = 0, fwft_sel = 0, def_sel = 0;
  logic wr_en = 0, ld = 0, ser_en = 0, ser_din = 0, rd_en = 0, rt = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_flag, wr_flag, half_full, almost_empty, almost_full;

  int n_chk = 0, n_err = 0;
  bit tb_fwft = 0;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] saved[$];

  always #5 wr_clk = ~wr_clk;
  always #7 rd_clk = ~rd_clk;

  dcfifo_pflag dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
    .def_sel(def_sel), .wr_en(wr_en), .wr_data(wr_data), .ld(ld), .ser_en(ser_en),
    .ser_din(ser_din), .rd_en(rd_en), .rt(rt), .rd_data(rd_data), .rd_flag(rd_flag),
    .wr_flag(wr_flag), .half_full(half_full), .almost_empty(almost_empty),
    .almost_full(almost_full)
  );

  function automatic int exp_hf(int k);            return (k > DEPTH / 2) ? 1 : 0; endfunction
  function automatic int exp_ae(int k, int off);   return (k <= off) ? 1 : 0; endfunction
  function automatic int exp_af(int k, int off);   return ((DEPTH - k) <= off) ? 1 : 0; endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic do_reset(bit master, bit fw, bit ds);
    @(negedge wr_clk);
    if (master) mrst = 1; else prst = 1;
    fwft_sel = fw; def_sel = ds;
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk);
    mrst = 0; prst = 0;
    if (master) tb_fwft = fw;
    mq.delete();
    settle();
  endtask

  task automatic put(logic [DW-1:0] d);
    bit space;
    @(negedge wr_clk);
    space = tb_fwft ? wr_flag : !wr_flag;
    wr_en = 1; wr_data = d;
    if (space) mq.push_back(d);
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic put_n(int n);
    repeat (n) put(DW'($urandom));
  endtask

  task automatic get_std(string tag);
    bit ok;
    @(negedge rd_clk);
    ok = !rd_flag;
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    if (ok) chk(tag, rd_data, mq.pop_front());
  endtask

  task automatic get_fw(string tag);
    @(negedge rd_clk);
    if (rd_flag) begin
      chk(tag, rd_data, mq.pop_front());
      rd_en = 1;
      @(negedge rd_clk);
      rd_en = 0;
    end
  endtask

  task automatic random_stream(bit fw);
    fork
      begin
        for (int i = 0; i < 150; ) begin
          @(negedge wr_clk);
          if ((fw ? wr_flag : !wr_flag) && ($urandom % 3 != 0)) begin
            logic [DW-1:0] d;
            d = DW'($urandom);
            wr_en = 1; wr_data = d; mq.push_back(d); i++;
          end else wr_en = 0;
        end
        @(negedge wr_clk) wr_en = 0;
      end
      begin
        int got;
        bit pend;
        got = 0; pend = 0;
        while (got < 150) begin
          @(negedge rd_clk);
          if (fw) begin
            if (rd_flag && ($urandom % 2 == 1)) begin
              chk("R1 fall-through stream order", rd_data, mq.pop_front());
              got++; rd_en = 1;
            end else rd_en = 0;
          end else begin
            if (pend) begin
              chk("R1 standard stream order", rd_data, mq.pop_front());
              got++;
            end
            pend = 0;
            if (got < 150 && !rd_flag && ($urandom % 2 == 1)) begin
              rd_en = 1; pend = 1;
            end else rd_en = 0;
          end
        end
        rd_en = 0;
      end
    join
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_err++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [DW-1:0] w;
    logic [11:0] sv;
    void'($urandom(32'd4242));

    // R9 reset state, standard mode, default thresholds 7
    do_reset(1, 0, 0);
    chk("R9 reset rd_flag empty", rd_flag, 1);
    chk("R9 reset wr_flag", wr_flag, 0);
    chk("R9 reset almost_empty", almost_empty, 1);
    chk("R9 reset almost_full", almost_full, 0);
    chk("R9 reset half_full", half_full, 0);

    // R14 first-word latency, R2 output only on read
    w = 18'h2A5C3;
    put(w);
    repeat (4) @(negedge rd_clk);
    chk("R14 not empty within four read clocks", rd_flag, 0);
    chk("R2 rd_data unchanged before read", rd_data, 0);
    get_std("R2 first word after read");
    settle();
    chk("R2 empty after draining", rd_flag, 1);

    // R5 read while empty ignored
    @(negedge rd_clk) rd_en = 1;
    @(negedge rd_clk) rd_en = 0;
    settle();
    chk("R5 rd_data kept on empty read", rd_data, w);
    put(18'h00F0F);
    settle();
    get_std("R5 pointer not moved by empty read");

    // R4 R6 R7 R8 fill sweep
    for (int k = 1; k <= DEPTH; k++) begin
      put(DW'($urandom));
      settle();
      chk($sformatf("R6 half_full at %0d", k), half_full, exp_hf(k));
      chk($sformatf("R7 almost_empty at %0d", k), almost_empty, exp_ae(k, 7));
      chk($sformatf("R8 almost_full at %0d", k), almost_full, exp_af(k, 7));
      chk($sformatf("R4 full flag at %0d", k), wr_flag, (k == DEPTH) ? 1 : 0);
    end
    put(18'h3FFFF);
    settle();
    repeat (DEPTH) get_std("R4 data intact after dropped write");
    settle();
    chk("R4 empty after draining full buffer", rd_flag, 1);

    // R9 alternate default threshold 15
    do_reset(1, 0, 1);
    put_n(15); settle();
    chk("R9 def_sel=1 almost_empty at 15", almost_empty, 1);
    put_n(1); settle();
    chk("R9 def_sel=1 almost_empty at 16", almost_empty, 0);

    // R11 parallel load: empty threshold 3, full threshold 5
    do_reset(1, 0, 0);
    @(negedge wr_clk) begin ld = 1; wr_en = 1; wr_data = 18'd3; end
    @(negedge wr_clk) wr_data = 18'd5;
    @(negedge wr_clk) begin ld = 0; wr_en = 0; end
    settle();
    chk("R11 load writes store no data", rd_flag, 1);
    put_n(3); settle();
    chk("R11 almost_empty at 3", almost_empty, exp_ae(3, 3));
    put_n(1); settle();
    chk("R11 almost_empty at 4", almost_empty, exp_ae(4, 3));
    put_n(54); settle();
    chk("R11 almost_full at 58", almost_full, exp_af(58, 5));
    put_n(1); settle();
    chk("R11 almost_full at 59", almost_full, exp_af(59, 5));

    // R10 partial reset keeps thresholds and mode
    do_reset(0, 0, 0);
    chk("R10 empty after partial reset", rd_flag, 1);
    chk("R10 half_full cleared", half_full, 0);
    put_n(3); settle();
    chk("R10 kept empty threshold at 3", almost_empty, 1);
    put_n(1); settle();
    chk("R10 kept empty threshold at 4", almost_empty, 0);

    // R12 serial load: empty threshold 2, full threshold 9
    do_reset(1, 0, 0);
    sv = {6'd9, 6'd2};
    @(negedge wr_clk) ser_en = 1;
    for (int i = 0; i < 12; i++) begin
      ser_din = sv[i];
      @(negedge wr_clk);
    end
    ser_en = 0;
    settle();
    chk("R12 serial shifts store no data", rd_flag, 1);
    put_n(2); settle();
    chk("R12 almost_empty at 2", almost_empty, exp_ae(2, 2));
    put_n(1); settle();
    chk("R12 almost_empty at 3", almost_empty, exp_ae(3, 2));
    put_n(51); settle();
    chk("R12 almost_full at 54", almost_full, exp_af(54, 9));
    put_n(1); settle();
    chk("R12 almost_full at 55", almost_full, exp_af(55, 9));

    // R9 master reset restores defaults
    do_reset(1, 0, 0);
    put_n(7); settle();
    chk("R9 default restored at 7", almost_empty, 1);
    put_n(1); settle();
    chk("R9 default restored at 8", almost_empty, 0);

    // R3 fall-through mode
    do_reset(1, 1, 0);
    chk("R9 fall-through reset rd_flag", rd_flag, 0);
    chk("R9 fall-through reset wr_flag ready", wr_flag, 1);
    w = 18'h1B00D;
    put(w);
    repeat (4) @(negedge rd_clk);
    chk("R14 fall-through word ready within four read clocks", rd_flag, 1);
    chk("R3 word presented without read", rd_data, w);
    put_n(DEPTH);
    settle();
    chk("R4 fall-through full at depth+1", wr_flag, 0);
    put(18'h3FFFF);
    settle();
    repeat (DEPTH + 1) get_fw("R3 fall-through drain order");
    settle();
    chk("R3 not ready after drain", rd_flag, 0);
    chk("R4 dropped write absent", mq.size(), 0);

    // R1 random concurrent streams
    random_stream(1);
    do_reset(1, 0, 0);
    random_stream(0);

    // R13 retransmit, standard mode
    do_reset(1, 0, 0);
    put_n(10); settle();
    saved = mq;
    repeat (4) get_std("R13 pre-retransmit reads");
    @(negedge rd_clk) rt = 1;
    @(negedge rd_clk) rt = 0;
    settle();
    mq = saved;
    repeat (10) get_std("R13 replay after retransmit");

    // R13 retransmit, fall-through mode
    do_reset(1, 1, 0);
    put_n(5); settle();
    saved = mq;
    repeat (2) get_fw("R13 fall-through pre-retransmit");
    @(negedge rd_clk) rt = 1;
    @(negedge rd_clk) rt = 0;
    settle();
    chk("R13 fall-through ready after retransmit", rd_flag, 1);
    chk("R13 first word falls through again", rd_data, saved[0]);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule